// File: doc/BRIEF.md
# Window Threshold Interrupt Generator

This block watches the stream of completed channel-0 light conversion results. It raises an interrupt when a result falls outside a programmable window. The window has a 16-bit lower bound and a 16-bit upper bound. Software writes each bound one byte at a time through a small byte-wide register port, and can read every byte back at the address it was written to.

The interrupt line is a level. Once set, it holds until software pulses the clear strobe. A global enable input decides whether a new result may set the line. Channel-1 results reach the block on their own input, but they never take part in the decision. The compare is asymmetric: a result equal to the lower bound counts as out of window, while a result equal to the upper bound does not.

Top module: `win_thresh_irq`

## Requirements
- R1: After a synchronous reset, all four threshold bytes read 0x00 and `irq` is low.
- R2: Byte writes use a fixed map. Address 2 is the lower bound bits 7:0, address 3 is the lower bound bits 15:8, address 4 is the upper bound bits 7:0 and address 5 is the upper bound bits 15:8. A write changes only the addressed byte, and the new value takes effect on the clock edge at which `wr_en` is sampled high.
- R3: `rd_data` shows, without a clock delay, the stored byte at the address on `addr` for addresses 2 to 5. Any other address reads 0x00, and a write to any other address changes no stored byte.
- R4: A valid result that is less than or equal to the lower bound sets `irq` on the edge that samples `res_valid`.
- R5: A valid result that is strictly greater than the upper bound sets `irq`. A result equal to the upper bound does not set it.
- R6: A result that lies strictly above the lower bound and at or below the upper bound leaves `irq` low. A result present while `res_valid` is low is never evaluated.
- R7: Once set, `irq` stays high on every following edge until `irq_clr` is sampled high.
- R8: `irq_clr` drops `irq` on the next edge. If an out-of-window valid result arrives in the same cycle as the clear, `irq` stays high.
- R9: While `irq_en` is low, no valid result sets `irq`.
- R10: The value on `res_ch1` has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 4 | Register byte address |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte read at `addr` (combinational) |
| res_ch0 | input | 16 | Channel-0 conversion result |
| res_ch1 | input | 16 | Channel-1 conversion result (not compared) |
| res_valid | input | 1 | One-cycle pulse marking a completed result |
| irq_en | input | 1 | Global enable for setting the interrupt |
| irq_clr | input | 1 | Interrupt clear strobe |
| irq | output | 1 | Sticky level interrupt |

## Verification
Each result has a fixed timing. A threshold write shows on `rd_data` one edge after the strobe. A valid result or a clear shows on `irq` one edge after it is sampled. Read-back is combinational on `addr`. The bench drives every stimulus on a falling edge and holds it through exactly one rising edge. It then samples at the next falling edge, so every check looks at the design half a cycle after the single edge that is due to update it. Read checks set `addr` at a falling edge and sample a short delay later, with no clock edge in between.

// File: rtl/win_irq_pkg.sv
package win_irq_pkg;

    parameter int unsigned RES_W     = 16;
    parameter int unsigned BYTE_W    = 8;
    parameter int unsigned ADDR_W    = 4;
    parameter int unsigned BASE_ADDR = 2;

    // Outcome of one window compare.
    typedef struct packed {
        logic below;   // result at or under the lower bound
        logic above;   // result strictly over the upper bound
    } cmp_t;

    typedef enum logic [1:0] {
        ZONE_INSIDE = 2'd0,
        ZONE_LOW    = 2'd1,
        ZONE_HIGH   = 2'd2
    } zone_e;

    function automatic zone_e classify(input cmp_t c);
        if (c.below)      return ZONE_LOW;
        else if (c.above) return ZONE_HIGH;
        else              return ZONE_INSIDE;
    endfunction

endpackage

// File: rtl/win_thr_regs.sv
module win_thr_regs
    import win_irq_pkg::*;
#(
    parameter int unsigned P_RES_W  = RES_W,
    parameter int unsigned P_BYTE_W = BYTE_W,
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_BASE   = BASE_ADDR
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] addr,
    input  logic [P_BYTE_W-1:0] wr_data,
    output logic [P_BYTE_W-1:0] rd_data,
    output logic [P_RES_W-1:0]  lo_thr,
    output logic [P_RES_W-1:0]  hi_thr
);
    localparam int unsigned NB   = P_RES_W / P_BYTE_W;
    localparam int unsigned NREG = 2 * NB;

    logic [P_BYTE_W-1:0] store [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_byte
        localparam logic [P_ADDR_W-1:0] MY_ADDR = P_ADDR_W'(P_BASE + g);
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (wr_en && addr == MY_ADDR)
                store[g] <= wr_data;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_join
        assign lo_thr[b*P_BYTE_W +: P_BYTE_W] = store[b];
        assign hi_thr[b*P_BYTE_W +: P_BYTE_W] = store[NB+b];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == P_ADDR_W'(P_BASE + i))
                rd_data = store[i];
        end
    end

endmodule

// File: rtl/win_cmp.sv
module win_cmp
    import win_irq_pkg::*;
#(
    parameter int unsigned P_RES_W = RES_W
) (
    input  logic [P_RES_W-1:0] res,
    input  logic [P_RES_W-1:0] lo_thr,
    input  logic [P_RES_W-1:0] hi_thr,
    output cmp_t               cmp
);
    // Lower edge inclusive, upper edge exclusive.
    always_comb begin
        cmp.below = (res <= lo_thr);
        cmp.above = (res >  hi_thr);
    end
endmodule

// File: rtl/win_irq_latch.sv
module win_irq_latch
    import win_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eval,
    input  cmp_t cmp,
    input  logic clr,
    output logic irq
);
    zone_e zone;
    logic  hit;

    always_comb begin
        zone = classify(cmp);
        hit  = eval && (zone != ZONE_INSIDE);
    end

    // A new hit outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (hit)
            irq <= 1'b1;
        else if (clr)
            irq <= 1'b0;
    end
endmodule

// File: rtl/win_thresh_irq.sv
module win_thresh_irq
    import win_irq_pkg::*;
#(
    parameter int unsigned P_RES_W  = RES_W,
    parameter int unsigned P_BYTE_W = BYTE_W,
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_BASE   = BASE_ADDR
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] addr,
    input  logic [P_BYTE_W-1:0] wr_data,
    output logic [P_BYTE_W-1:0] rd_data,
    input  logic [P_RES_W-1:0]  res_ch0,
    input  logic [P_RES_W-1:0]  res_ch1,
    input  logic                res_valid,
    input  logic                irq_en,
    input  logic                irq_clr,
    output logic                irq
);
    logic [P_RES_W-1:0] lo_thr;
    logic [P_RES_W-1:0] hi_thr;
    cmp_t               cmp;
    logic               eval;
    logic [P_RES_W-1:0] ch1_unused;

    assign ch1_unused = res_ch1;   // second channel is not part of the window test
    assign eval       = res_valid && irq_en;

    win_thr_regs #(
        .P_RES_W(P_RES_W), .P_BYTE_W(P_BYTE_W),
        .P_ADDR_W(P_ADDR_W), .P_BASE(P_BASE)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .lo_thr(lo_thr), .hi_thr(hi_thr)
    );

    win_cmp #(.P_RES_W(P_RES_W)) u_cmp (
        .res(res_ch0), .lo_thr(lo_thr), .hi_thr(hi_thr), .cmp(cmp)
    );

    win_irq_latch u_latch (
        .clk(clk), .rst(rst), .eval(eval), .cmp(cmp),
        .clr(irq_clr), .irq(irq)
    );
endmodule

// File: rtl/win_thresh_irq_chk.sv
module win_thresh_irq_chk #(
    parameter int unsigned P_RES_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [P_RES_W-1:0] res_ch0,
    input logic               res_valid,
    input logic               irq_en,
    input logic               irq_clr,
    input logic               irq,
    input logic [P_RES_W-1:0] lo_thr,
    input logic [P_RES_W-1:0] hi_thr
);
    logic out_win;
    assign out_win = res_valid && irq_en &&
                     ((res_ch0 <= lo_thr) || (res_ch0 > hi_thr));

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!irq && lo_thr == '0 && hi_thr == '0));

    // R4
    a_r4_low_sets: assert property (@(posedge clk) disable iff (rst)
        (res_valid && irq_en && res_ch0 <= lo_thr) |=> irq);

    // R5
    a_r5_high_sets: assert property (@(posedge clk) disable iff (rst)
        (res_valid && irq_en && res_ch0 > hi_thr) |=> irq);

    // R7
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    // R8
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !out_win) |=> !irq);

    // R9
    a_r9_disabled: assert property (@(posedge clk) disable iff (rst)
        (!irq && !irq_en) |=> !irq);

    // R6
    a_r6_no_valid: assert property (@(posedge clk) disable iff (rst)
        (!irq && !res_valid) |=> !irq);
endmodule

bind win_thresh_irq win_thresh_irq_chk #(.P_RES_W(P_RES_W)) u_chk (
    .clk(clk), .rst(rst), .res_ch0(res_ch0), .res_valid(res_valid),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq),
    .lo_thr(lo_thr), .hi_thr(hi_thr)
);

// File: tb/win_thresh_irq_bench.sv
`timescale 1ns/1ps
module win_thresh_irq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic [15:0] res_ch0;
    logic [15:0] res_ch1;
    logic        res_valid;
    logic        irq_en;
    logic        irq_clr;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;   // 125 MHz

    win_thresh_irq u_win_thresh_irq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .res_ch0(res_ch0), .res_ch1(res_ch1),
        .res_valid(res_valid), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, int'(rd_data), int'(exp));
    endtask

    // One valid result, optionally with a clear in the same cycle.
    task automatic send(input logic [15:0] r0, input logic [15:0] r1, input logic clr);
        @(negedge clk);
        res_ch0 = r0; res_ch1 = r1; res_valid = 1'b1; irq_clr = clr;
        @(negedge clk);
        res_valid = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic set_window(input logic [15:0] lo, input logic [15:0] hi);
        wr(4'd2, lo[7:0]);  wr(4'd3, lo[15:8]);
        wr(4'd4, hi[7:0]);  wr(4'd5, hi[15:8]);
    endtask

    task automatic t_reset();
        check("R1 irq", int'(irq), 0);
        for (int a = 2; a <= 5; a++) rd_check("R1 thr byte", 4'(a), 8'h00);
    endtask

    task automatic t_regs();
        wr(4'd2, 8'h34);
        rd_check("R2 lo low byte", 4'd2, 8'h34);
        rd_check("R2 lo high untouched", 4'd3, 8'h00);
        wr(4'd3, 8'h12); wr(4'd4, 8'hCD); wr(4'd5, 8'hAB);
        rd_check("R3 readback a3", 4'd3, 8'h12);
        rd_check("R3 readback a4", 4'd4, 8'hCD);
        rd_check("R3 readback a5", 4'd5, 8'hAB);
        wr(4'd6, 8'h77); wr(4'd1, 8'h55);
        rd_check("R3 unmapped a6", 4'd6, 8'h00);
        rd_check("R3 unmapped a1", 4'd1, 8'h00);
        rd_check("R3 a2 kept", 4'd2, 8'h34);
        rd_check("R3 a5 kept", 4'd5, 8'hAB);
    endtask

    task automatic t_low();
        send(16'h1235, 16'h0, 1'b0);
        check("R6 just above low", int'(irq), 0);
        send(16'h1234, 16'h0, 1'b0);
        check("R4 equal low", int'(irq), 1);
        clear();
        check("R8 clear", int'(irq), 0);
        send(16'h1233, 16'h0, 1'b0);
        check("R4 below low", int'(irq), 1);
        clear();
    endtask

    task automatic t_high();
        send(16'hABCD, 16'h0, 1'b0);
        check("R5 equal high", int'(irq), 0);
        send(16'hABCE, 16'h0, 1'b0);
        check("R5 above high", int'(irq), 1);
        clear();
    endtask

    task automatic t_novalid();
        @(negedge clk);
        res_ch0 = 16'h0000; res_valid = 1'b0;
        @(negedge clk);
        check("R6 no valid", int'(irq), 0);
    endtask

    task automatic t_sticky();
        send(16'hFFFF, 16'h0, 1'b0);
        send(16'h5000, 16'h0, 1'b0);
        repeat (3) @(negedge clk);
        check("R7 sticky", int'(irq), 1);
        send(16'h0001, 16'h0, 1'b1);
        check("R8 hit beats clear", int'(irq), 1);
        clear();
        check("R8 clear after", int'(irq), 0);
    endtask

    task automatic t_enable();
        irq_en = 1'b0;
        send(16'h0000, 16'h0, 1'b0);
        check("R9 disabled low", int'(irq), 0);
        send(16'hFFFF, 16'h0, 1'b0);
        check("R9 disabled high", int'(irq), 0);
        irq_en = 1'b1;
    endtask

    task automatic t_ch1();
        send(16'h5000, 16'h0000, 1'b0);
        check("R10 ch1 zero", int'(irq), 0);
        send(16'h5000, 16'hFFFF, 1'b0);
        check("R10 ch1 max", int'(irq), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
        res_ch0 = '0; res_ch1 = '0; res_valid = 1'b0;
        irq_en = 1'b1; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        set_window(16'h1234, 16'hABCD);
        t_low();
        t_high();
        t_novalid();
        t_sticky();
        t_enable();
        t_ch1();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule